// File: doc/BRIEF.md
# Character Lit Gate with Dimming, Blink and Flash

This block decides, for each scan slot of a multiplexed character display, whether the character being scanned is driven lit or dark. It merges three effects. The first is a pulse-width dimmer that takes a 3-bit brightness code. The second is a whole-display blink. The third is a per-character flash that affects only characters whose flash-memory bit is set. The scanner presents a character index and that character's flash bit together with a display clock enable. The block returns one gate bit that the row drivers AND into their output.

A display frame ends on a cycle where the clock enable is high and the index is at the last character. Every frame end advances a 15-slot dimming period and a free-running blink/flash divider. Reset clears both counters. Displays that share one clock and one reset therefore dim, blink and flash in step with one another.

Top module: `char_lit_gate`

## Requirements
- R1: With brightness code `ctrl[2:0]` of 000, 001, 010, 011, 100, 101 or 110, and with blink and flash disabled, the gate is lit during the first 15, 12, 8, 6, 4, 3 or 2 frames of every 15-frame dimming period. It is dark for the rest of the period.
- R2: With brightness code 111 the gate is never lit, whatever the other inputs are.
- R3: With `ctrl[3]` = 1 and `ctrl[4]` = 0, a character whose flash bit is 1 is dark during the off phase. A character whose flash bit is 0 follows the dimmer alone.
- R4: With `ctrl[4]` = 1, every character is dark during the off phase. `ctrl[3]` and the flash bit have no effect in either phase.
- R5: The divider counts frames modulo 2^DIV_W. The off phase covers counts 2^(DIV_W-1) through 2^DIV_W-1. With the default DIV_W of 5, a blinking display first goes dark 16 frames after reset.
- R6: Reset puts the dimming slot and the divider at zero. With code 000 the gate is lit in the first cycle after reset.
- R7: A frame ends only when `tick` is high and `char_idx` equals NCHAR-1. The counters do not move while `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Display clock enable, one scan slot per high cycle |
| ctrl | input | 5 | [2:0] brightness code, [3] flash enable, [4] blink enable |
| char_idx | input | $clog2(NCHAR) | Index of the character being scanned |
| flash_bit | input | 1 | Flash-memory bit of the scanned character |
| lit | output | 1 | Lit gate for the current scan slot |

## Verification
The dimmer's dark slots and the blink or flash off phase can fall in the same frame. A flashing character can also be scanned while blink is enabled, which raises the precedence question. The bench provokes both overlaps by running long stretches with blink and flash enabled together. It mixes flash bits and brightness codes across several divider periods, so the 15-frame and 32-frame cycles drift through every alignment. A behavioural model keeps its own frame count and compares the gate on every clock, so any wrong precedence or wrong overlap shows up as a mismatch in that cycle.

// File: rtl/lgate_pkg.sv
package lgate_pkg;

   localparam int PWM_SLOTS = 15;
   localparam int SLOT_W    = 4;

   typedef logic [2:0] bright_t;

   // Number of lit slots out of PWM_SLOTS for each brightness code; 7 blanks.
   function automatic logic [SLOT_W-1:0] on_slots(input bright_t code);
      logic [SLOT_W-1:0] n;
      case (code)
         3'd0:    n = 4'd15;
         3'd1:    n = 4'd12;
         3'd2:    n = 4'd8;
         3'd3:    n = 4'd6;
         3'd4:    n = 4'd4;
         3'd5:    n = 4'd3;
         3'd6:    n = 4'd2;
         default: n = 4'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/lgate_pwm.sv
module lgate_pwm
   import lgate_pkg::*;
#(
   parameter int SLOTS = PWM_SLOTS
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    adv,
   input  bright_t code,
   output logic    pwm_on
);

   localparam int CW = $clog2(SLOTS);

   if (SLOTS != PWM_SLOTS) begin : g_bad_slots
      $error("lgate_pwm: SLOTS must equal PWM_SLOTS");
   end

   logic [CW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= '0;
      else if (adv)
         slot_q <= (slot_q == CW'(SLOTS-1)) ? '0 : slot_q + 1'b1;
   end

   assign pwm_on = (SLOT_W'(slot_q) < on_slots(code));

   // R1
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q < CW'(SLOTS));

   // R7
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(slot_q));

   // R2
   blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'b111) |-> !pwm_on);

endmodule

// File: rtl/lgate_phase.sv
module lgate_phase #(
   parameter int DIV_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic off_phase
);

   if (DIV_W < 2) begin : g_bad_div
      $error("lgate_phase: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= cnt_q + 1'b1;
   end

   assign off_phase = cnt_q[DIV_W-1];

   // R5
   div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> cnt_q == DIV_W'($past(cnt_q) + 1'b1));

   // R7
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt_q));

endmodule

// File: rtl/char_lit_gate.sv
module char_lit_gate
   import lgate_pkg::*;
#(
   parameter int NCHAR   = 8,
   parameter int DIV_W   = 5,
   parameter bit REG_OUT = 1'b0,
   localparam int IDX_W  = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [4:0]       ctrl,
   input  logic [IDX_W-1:0] char_idx,
   input  logic             flash_bit,
   output logic             lit
);

   if (NCHAR < 2) begin : g_bad_nchar
      $error("char_lit_gate: NCHAR must be at least 2");
   end

   logic    frame_end;
   logic    pwm_on;
   logic    off_phase;
   logic    blink_en;
   logic    flash_en;
   logic    gate_c;
   bright_t code;

   assign code      = ctrl[2:0];
   assign flash_en  = ctrl[3];
   assign blink_en  = ctrl[4];
   assign frame_end = tick && (char_idx == IDX_W'(NCHAR-1));

   lgate_pwm u_pwm (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (frame_end),
      .code   (code),
      .pwm_on (pwm_on)
   );

   lgate_phase #(.DIV_W(DIV_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (frame_end),
      .off_phase (off_phase)
   );

   // Blink masks the whole display and overrides flash.
   always_comb begin
      gate_c = pwm_on;
      if (blink_en) begin
         if (off_phase) gate_c = 1'b0;
      end else if (flash_en && flash_bit && off_phase) begin
         gate_c = 1'b0;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lit <= 1'b0;
         else        lit <= gate_c;
      end
   end else begin : g_comb_out
      assign lit = gate_c;

      // R4
      blink_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (blink_en && off_phase) |-> !lit);

      // R3
      flash_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flash_en && flash_bit && off_phase) |-> !lit);

      // R2
      top_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (code == 3'b111) |-> !lit);
   end

endmodule

// File: tb/tb_char_lit_gate.sv
module tb_char_lit_gate;

   localparam int NCHAR = 8;
   localparam int DIV_W = 5;
   localparam int HALF  = 1 << (DIV_W - 1);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [4:0] ctrl = 5'd0;
   logic [2:0] char_idx = 3'd0;
   logic       flash_bit = 1'b0;
   logic       lit;

   int m_slot = 0;
   int m_div = 0;
   int checks = 0;
   int fails = 0;

   char_lit_gate #(.NCHAR(NCHAR), .DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
      .char_idx(char_idx), .flash_bit(flash_bit), .lit(lit)
   );

   always #4 clk = ~clk;

   // Reference frame counters
   always @(posedge clk) begin
      if (!rst_n) begin
         m_slot = 0;
         m_div  = 0;
      end else if (tick && char_idx == 3'(NCHAR-1)) begin
         m_slot = (m_slot + 1) % 15;
         m_div  = (m_div + 1) % (1 << DIV_W);
      end
   end

   function automatic int onc(input int c);
      case (c)
         0: return 15; 1: return 12; 2: return 8; 3: return 6;
         4: return 4;  5: return 3;  6: return 2; default: return 0;
      endcase
   endfunction

   function automatic bit exp_lit();
      bit on, off;
      on  = (m_slot < onc(int'(ctrl[2:0])));
      off = (m_div >= HALF);
      if (ctrl[4] && off) on = 1'b0;
      else if (!ctrl[4] && ctrl[3] && flash_bit && off) on = 1'b0;
      return on;
   endfunction

   task automatic check(input bit got, input bit exp, input string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: lit=%0b expected=%0b (slot %0d div %0d ctrl %b)",
                  tag, got, exp, m_slot, m_div, ctrl);
      end
   endtask

   function automatic string tag_now();
      if (ctrl[2:0] == 3'b111) return "R2";
      if (ctrl[4]) return "R4";
      if (ctrl[3]) return "R3";
      return "R1";
   endfunction

   // One cycle: drive at the falling edge, compare with the model.
   task automatic step(input bit t, input bit fb);
      @(negedge clk);
      if (tick) char_idx = char_idx + 1'b1;
      tick = t;
      flash_bit = fb;
      #1;
      if (rst_n) check(lit, exp_lit(), tag_now());
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick = 1'b0;
      char_idx = 3'd0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int cnt;
      bit held;

      // R6: reset state, code 000 lit in first cycle
      ctrl = 5'b00000;
      do_reset();
      #1;
      check(lit, 1'b1, "R6");

      // R1: duty per code over one 15-frame period
      for (int c = 0; c < 7; c++) begin
         ctrl = 5'(c);
         do_reset();
         cnt = 0;
         for (int s = 0; s < 15 * NCHAR; s++) begin
            step(1'b1, 1'b0);
            if (char_idx == 3'd0 && lit) cnt++;
         end
         check(cnt == onc(c), 1'b1, "R1");
         if (cnt != onc(c))
            $display("FAIL R1: code %0d lit frames=%0d expected=%0d", c, cnt, onc(c));
      end

      // R2: blank code never lit, even with toggling flash bits
      ctrl = 5'b11111;
      do_reset();
      cnt = 0;
      for (int s = 0; s < 300; s++) begin
         step(1'b1, s[0]);
         if (lit) cnt++;
      end
      check(cnt == 0, 1'b1, "R2");

      // R5: blink first goes dark after HALF frames
      ctrl = 5'b10000;
      do_reset();
      cnt = 0;
      for (int s = 0; s < 400; s++) begin
         step(1'b1, 1'b0);
         if (!lit) break;
         cnt++;
      end
      check(cnt == HALF * NCHAR, 1'b1, "R5");
      if (cnt != HALF * NCHAR)
         $display("FAIL R5: lit cycles=%0d expected=%0d", cnt, HALF * NCHAR);

      // R3: flash with mixed flash bits, full period lit counts
      ctrl = 5'b01000;
      do_reset();
      cnt = 0;
      for (int s = 0; s < 2 * HALF * NCHAR; s++) begin
         step(1'b1, 1'b1);
         if (lit) cnt++;
      end
      check(cnt == HALF * NCHAR, 1'b1, "R3");
      cnt = 0;
      for (int s = 0; s < 2 * HALF * NCHAR; s++) begin
         step(1'b1, 1'b0);
         if (lit) cnt++;
      end
      check(cnt == 2 * HALF * NCHAR, 1'b1, "R3");

      // R4: blink with flash also enabled: precedence over several periods
      ctrl = 5'b11000;
      do_reset();
      for (int s = 0; s < 6 * HALF * NCHAR; s++) step(1'b1, s[1] ^ s[4]);
      ctrl = 5'b11010;
      for (int s = 0; s < 6 * HALF * NCHAR; s++) step(s[0] | s[2], s[0]);

      // Mixed overlap of dimmer and flash, irregular tick
      ctrl = 5'b01011;
      for (int s = 0; s < 3000; s++) step((s % 3) != 0, s[2]);
      ctrl = 5'b00101;
      for (int s = 0; s < 1500; s++) step(s[0] | s[3], s[1]);

      // R7: tick low freezes counters; lit stays put
      ctrl = 5'b10100;
      do_reset();
      for (int s = 0; s < 37; s++) step(1'b1, 1'b0);
      held = lit;
      for (int s = 0; s < 200; s++) begin
         step(1'b0, 1'b0);
         check(lit, held, "R7");
      end

      // R6: mid-run reset restarts phase
      ctrl = 5'b00000;
      for (int s = 0; s < 50; s++) step(1'b1, 1'b0);
      do_reset();
      #1;
      check(lit, 1'b1, "R6");
      ctrl = 5'b00110;
      #1;
      check(lit, 1'b1, "R6");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule